// File: doc/BRIEF.md
# Mining Nonce Capture and Serial Reporter

This block sits at the output of a double-SHA256 search pipeline. The pipeline produces a new outer hash in every clock cycle. The block checks each result as it appears. When the top 32 hash bits are all zero and the pipeline step counter is zero, it records the nonce that belongs to that result in the same cycle. A winning result is visible for only one cycle, so it cannot wait.

Recorded nonces go into a 16-entry queue of 64-bit entries. A byte-serial transmitter drains the queue toward the host controller at a baud rate far below the hash clock. Several wins may arrive while one nonce is still being sent. They wait in the queue and go out one after another, with no gap between frames. A win that finds the queue full is lost, and a sticky flag records the loss. The bit-time divider is derived from two parameters, the clock frequency and the baud rate, so a new clock rate needs no hand edits to counter widths.

Top module: `nonce_report_top`

## Requirements
- R1: While `rst` is high at a rising edge, the queue is emptied, the transmitter returns to idle, `tx_o` is 1 and `overflow_o` is 0 after that edge.
- R2: A win is recorded only in a cycle where `valid_i` is 1, `hash_i[255:224]` is all zero and `step_i` is zero. The values of `hash_i[223:0]` have no effect. If any one of the three conditions fails, nothing is queued and nothing is sent.
- R3: The nonce is taken from `nonce_i` at the same edge that samples the win. Wins on consecutive cycles are each recorded, in order. Each 64-bit entry holds the nonce in bits [31:0], and bits [63:32] are zero.
- R4: Each nonce is sent as 4 bytes, most significant byte first. Each byte is framed as 8N1: a start bit of 0, then 8 data bits LSB first, then a stop bit of 1. Every bit lasts DIV = round(CLK_HZ/BAUD) clock cycles, so a frame is 40·DIV cycles long.
- R5: When the transmitter is idle and the queue is empty, a win sampled at edge k drives `tx_o` low (the start bit) at edge k+1.
- R6: If the queue holds an entry when the stop bit of a frame's last byte ends, the next frame's start bit follows in the very next cycle. No idle cycle is inserted. The line idles high only when the queue is empty.
- R7: The queue holds 16 entries and releases them in arrival order. The check for a full queue uses the occupancy before the edge, even if an entry is removed at that same edge. A win that arrives when the queue is full is dropped.
- R8: `overflow_o` rises at the edge after a dropped win. It then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Hash-pipeline clock |
| rst | input | 1 | Synchronous active-high reset |
| hash_i | input | 256 | Outer hash of the current pipeline result |
| step_i | input | 6 | Pipeline step counter |
| nonce_i | input | 32 | Nonce that belongs to the current result |
| valid_i | input | 1 | Current result is meaningful |
| tx_o | output | 1 | Serial line to host, idles high |
| overflow_o | output | 1 | Sticky flag: a win was dropped |

## Verification
A win enters the queue at the edge that samples it. On an idle link, its start bit appears one edge later. Each bit then lasts exactly DIV cycles, and the next queued frame begins exactly 40·DIV cycles after the previous one began. The overflow flag follows a dropped win by one edge. The bench steps a behavioural model at every rising edge. It compares `tx_o` and `overflow_o` with that model half a cycle later, so each result is sampled in the cycle it falls due. Separate checks cover three more points: the one-edge start latency, the frame-to-frame spacing, and the bytes decoded at mid-bit.

// File: rtl/nonce_rpt_pkg.sv
package nonce_rpt_pkg;
    // Bits in one serial byte frame: start, 8 data, stop.
    localparam int FRAME_BITS = 10;

    // Clock cycles per serial bit, rounded to the nearest integer.
    function automatic int baud_div(int clk_hz, int baud);
        return (clk_hz + baud / 2) / baud;
    endfunction
endpackage

// File: rtl/nonce_hit_detect.sv
module nonce_hit_detect #(
    parameter int HASH_W    = 256,
    parameter int ZERO_BITS = 32,
    parameter int STEP_W    = 6,
    parameter int NONCE_W   = 32,
    parameter int ENTRY_W   = 64
) (
    input  logic [HASH_W-1:0]  hash_i,
    input  logic [STEP_W-1:0]  step_i,
    input  logic [NONCE_W-1:0] nonce_i,
    input  logic               valid_i,
    output logic               hit_o,
    output logic [ENTRY_W-1:0] entry_o
);
    // Difficulty mask: only the leading ZERO_BITS of the hash must be zero.
    localparam logic [HASH_W-1:0] TARGET_MASK =
        {{ZERO_BITS{1'b1}}, {(HASH_W-ZERO_BITS){1'b0}}};

    always_comb begin
        hit_o = valid_i && ((hash_i & TARGET_MASK) == '0) && (step_i == '0);
    end

    generate
        if (ENTRY_W > NONCE_W) begin : g_pad
            assign entry_o = {{(ENTRY_W-NONCE_W){1'b0}}, nonce_i};
        end else begin : g_flat
            assign entry_o = nonce_i;
        end
    endgenerate
endmodule

// File: rtl/nonce_fifo.sv
module nonce_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en_i,
    input  logic [WIDTH-1:0]             wr_data_i,
    input  logic                         rd_en_i,
    output logic [WIDTH-1:0]             head_o,
    output logic                         empty_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         dropped_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wr;
        logic [PTR_W-1:0]            rd;
        logic [CNT_W-1:0]            cnt;
        logic                        drop;
    } fifo_st_t;

    fifo_st_t s_d, s_q;

    always_comb begin
        logic full, empty, do_wr, do_rd;
        s_d   = s_q;
        full  = (s_q.cnt == CNT_W'(DEPTH));
        empty = (s_q.cnt == '0);
        do_wr = wr_en_i && !full;
        do_rd = rd_en_i && !empty;
        if (do_wr) begin
            s_d.mem[s_q.wr] = wr_data_i;
            s_d.wr = (s_q.wr == PTR_W'(DEPTH-1)) ? '0 : s_q.wr + 1'b1;
        end
        if (do_rd) begin
            s_d.rd = (s_q.rd == PTR_W'(DEPTH-1)) ? '0 : s_q.rd + 1'b1;
        end
        s_d.cnt = s_q.cnt + CNT_W'(do_wr) - CNT_W'(do_rd);
        if (wr_en_i && full) begin
            s_d.drop = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.mem  <= s_d.mem;
            s_q.wr   <= '0;
            s_q.rd   <= '0;
            s_q.cnt  <= '0;
            s_q.drop <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head_o    = s_q.mem[s_q.rd];
    assign empty_o   = (s_q.cnt == '0);
    assign count_o   = s_q.cnt;
    assign dropped_o = s_q.drop;
endmodule

// File: rtl/nonce_serial_tx.sv
module nonce_serial_tx
    import nonce_rpt_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int BAUD   = 115_200,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              avail_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              take_o,
    output logic              tx_o
);
    localparam int DIV    = baud_div(CLK_HZ, BAUD);
    localparam int DIV_W  = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int BYTES  = WORD_W / 8;
    localparam int BYTE_W = (BYTES > 1) ? $clog2(BYTES) : 1;

    typedef struct packed {
        logic              busy;
        logic [DIV_W-1:0]  div;
        logic [3:0]        bitn;
        logic [BYTE_W-1:0] byten;
        logic [WORD_W-1:0] word;
        logic              tx;
    } tx_st_t;

    tx_st_t s_d, s_q;

    always_comb begin
        logic       frame_end;
        logic [7:0] cur_byte;
        logic [2:0] bsel;
        s_d       = s_q;
        take_o    = 1'b0;
        frame_end = 1'b0;
        if (s_q.busy) begin
            if (s_q.div == DIV_W'(DIV-1)) begin
                s_d.div = '0;
                if (s_q.bitn == 4'(FRAME_BITS-1)) begin
                    s_d.bitn = '0;
                    if (s_q.byten == BYTE_W'(BYTES-1)) begin
                        s_d.byten = '0;
                        frame_end = 1'b1;
                    end else begin
                        s_d.byten = s_q.byten + 1'b1;
                    end
                end else begin
                    s_d.bitn = s_q.bitn + 1'b1;
                end
            end else begin
                s_d.div = s_q.div + 1'b1;
            end
        end
        if (!s_q.busy || frame_end) begin
            if (avail_i) begin
                take_o    = 1'b1;
                s_d.busy  = 1'b1;
                s_d.word  = word_i;
                s_d.div   = '0;
                s_d.bitn  = '0;
                s_d.byten = '0;
            end else begin
                s_d.busy = 1'b0;
            end
        end
        // Byte order: most significant first; bit order inside a byte: LSB first.
        cur_byte = 8'(s_d.word >> (8 * (BYTES - 1 - int'(s_d.byten))));
        bsel     = 3'(s_d.bitn - 4'd1);
        if (!s_d.busy)                           s_d.tx = 1'b1;
        else if (s_d.bitn == '0)                 s_d.tx = 1'b0;
        else if (s_d.bitn == 4'(FRAME_BITS-1))   s_d.tx = 1'b1;
        else                                     s_d.tx = cur_byte[bsel];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.busy  <= 1'b0;
            s_q.div   <= '0;
            s_q.bitn  <= '0;
            s_q.byten <= '0;
            s_q.word  <= '0;
            s_q.tx    <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_o = s_q.tx;
endmodule

// File: rtl/nonce_report_top.sv
module nonce_report_top #(
    parameter int CLK_HZ     = 100_000_000,
    parameter int BAUD       = 115_200,
    parameter int HASH_W     = 256,
    parameter int ZERO_BITS  = 32,
    parameter int STEP_W     = 6,
    parameter int NONCE_W    = 32,
    parameter int ENTRY_W    = 64,
    parameter int FIFO_DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HASH_W-1:0]  hash_i,
    input  logic [STEP_W-1:0]  step_i,
    input  logic [NONCE_W-1:0] nonce_i,
    input  logic               valid_i,
    output logic               tx_o,
    output logic               overflow_o
);
    localparam int CNT_W = $clog2(FIFO_DEPTH+1);

    logic               hit;
    logic [ENTRY_W-1:0] entry;
    logic [ENTRY_W-1:0] fifo_head;
    logic               fifo_empty;
    logic [CNT_W-1:0]   fifo_cnt;
    logic               take;

    nonce_hit_detect #(
        .HASH_W(HASH_W), .ZERO_BITS(ZERO_BITS), .STEP_W(STEP_W),
        .NONCE_W(NONCE_W), .ENTRY_W(ENTRY_W)
    ) u_detect (
        .hash_i(hash_i), .step_i(step_i), .nonce_i(nonce_i),
        .valid_i(valid_i), .hit_o(hit), .entry_o(entry)
    );

    nonce_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENTRY_W)) u_fifo (
        .clk(clk), .rst(rst),
        .wr_en_i(hit), .wr_data_i(entry),
        .rd_en_i(take), .head_o(fifo_head),
        .empty_o(fifo_empty), .count_o(fifo_cnt),
        .dropped_o(overflow_o)
    );

    nonce_serial_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .WORD_W(NONCE_W)) u_tx (
        .clk(clk), .rst(rst),
        .avail_i(!fifo_empty), .word_i(fifo_head[NONCE_W-1:0]),
        .take_o(take), .tx_o(tx_o)
    );
endmodule

// File: rtl/nonce_report_checks.sv
module nonce_report_checks #(
    parameter int DEPTH     = 16,
    parameter int CNT_W     = 5,
    parameter int ZERO_BITS = 32,
    parameter int STEP_W    = 6,
    parameter int RSV_W     = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ZERO_BITS-1:0] hash_top,
    input logic [STEP_W-1:0]    step,
    input logic                 valid,
    input logic                 tx,
    input logic                 ovf,
    input logic [CNT_W-1:0]     cnt,
    input logic                 empty,
    input logic                 take,
    input logic [RSV_W-1:0]     head_hi
);
    // R1: reset leaves the line high and the flag clear
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (tx && !ovf));

    // R2: occupancy grows only after a qualifying win was presented
    a_r2_grow_needs_win: assert property (@(posedge clk) disable iff (rst)
        (cnt > $past(cnt)) |-> $past(valid && step == '0 && hash_top == '0));

    // R3: reserved upper half of a stored entry is zero
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        !empty |-> (head_hi == '0));

    // R6: the transmitter never takes from an empty queue
    a_r6_take_nonempty: assert property (@(posedge clk) disable iff (rst)
        take |-> !empty);

    // R7: occupancy never exceeds the depth
    a_r7_depth_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH));

    // R8: flag rises only after a win met a full queue, then stays
    a_r8_flag_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> ($past(cnt) == CNT_W'(DEPTH) && $past(valid && step == '0 && hash_top == '0)));
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
endmodule

bind nonce_report_top nonce_report_checks #(
    .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .ZERO_BITS(ZERO_BITS),
    .STEP_W(STEP_W), .RSV_W(ENTRY_W-NONCE_W)
) u_checks (
    .clk(clk), .rst(rst),
    .hash_top(hash_i[HASH_W-1 -: ZERO_BITS]),
    .step(step_i), .valid(valid_i), .tx(tx_o), .ovf(overflow_o),
    .cnt(fifo_cnt), .empty(fifo_empty), .take(take),
    .head_hi(fifo_head[ENTRY_W-1:NONCE_W])
);

// File: tb/test_nonce_report_top.sv
module test_nonce_report_top;
    localparam int DIV   = 10;          // round(100 MHz / 10 Mbaud)
    localparam int FRAME = 40 * DIV;    // 4 bytes x 10 bits
    localparam int DEPTH = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [255:0] hash  = '0;
    logic [5:0]   step  = 6'd1;
    logic [31:0]  nonce = '0;
    logic         valid = 1'b0;
    logic         tx_o, overflow_o;

    int checks = 0, errors = 0, cyc = 0;
    string tag = "R1";
    bit cmp_en = 0;

    always #5 clk = ~clk;

    nonce_report_top #(.CLK_HZ(100_000_000), .BAUD(10_000_000)) i_nonce_report_top (
        .clk(clk), .rst(rst), .hash_i(hash), .step_i(step), .nonce_i(nonce),
        .valid_i(valid), .tx_o(tx_o), .overflow_o(overflow_o)
    );

    // ---------------- behavioural reference model ----------------
    int unsigned mq[$];
    bit m_ovf = 0, m_busy = 0, m_tx = 1;
    int m_pos = 0;
    int unsigned m_cur = 0;

    function automatic bit line_val(int unsigned w, int pos);
        int byte_i = pos / (10 * DIV);
        int bit_i  = (pos % (10 * DIV)) / DIV;
        if (bit_i == 0) return 1'b0;
        if (bit_i == 9) return 1'b1;
        return w[8 * (3 - byte_i) + bit_i - 1];
    endfunction

    always @(posedge clk) begin : model
        bit win, can_pop, full;
        cyc++;
        if (rst) begin
            mq.delete(); m_ovf = 0; m_busy = 0; m_pos = 0;
        end else begin
            win     = valid && hash[255:224] == 32'h0 && step == 6'd0;
            can_pop = mq.size() > 0;
            full    = mq.size() == DEPTH;
            if (m_busy) begin
                m_pos++;
                if (m_pos == FRAME) begin
                    if (can_pop) begin m_cur = mq.pop_front(); m_pos = 0; end
                    else m_busy = 0;
                end
            end else if (can_pop) begin
                m_cur = mq.pop_front(); m_pos = 0; m_busy = 1;
            end
            if (win) begin
                if (!full) mq.push_back(nonce);
                else m_ovf = 1;
            end
        end
        m_tx = m_busy ? line_val(m_cur, m_pos) : 1'b1;
        cmp_en = 1;
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            checks++;
            if (tx_o !== m_tx) begin
                errors++;
                $display("FAIL %s: tx_o=%b expected %b at cycle %0d", tag, tx_o, m_tx, cyc);
            end
            checks++;
            if (overflow_o !== m_ovf) begin
                errors++;
                $display("FAIL %s: overflow_o=%b expected %b at cycle %0d", tag, overflow_o, m_ovf, cyc);
            end
        end
    end

    // ---------------- mid-bit line decoder ----------------
    int unsigned rx_word[$];
    bit          rx_ok[$];
    int          rx_start[$];

    always begin : decoder
        int unsigned w;
        bit ok;
        int st;
        @(negedge clk);
        if (!rst && cmp_en && tx_o === 1'b0) begin
            st = cyc; w = 0; ok = 1;
            repeat (DIV / 2) @(negedge clk);
            for (int j = 0; j < 40; j++) begin
                if (j % 10 == 0)      ok &= (tx_o === 1'b0);
                else if (j % 10 == 9) ok &= (tx_o === 1'b1);
                else w[8 * (3 - j / 10) + (j % 10) - 1] = tx_o;
                if (j < 39) repeat (DIV) @(negedge clk);
            end
            rx_word.push_back(w); rx_ok.push_back(ok); rx_start.push_back(st);
        end
    end

    // ---------------- helpers ----------------
    task automatic check(bit cond, string req, string what, longint act, longint exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(logic [255:0] h, logic [5:0] s, logic [31:0] n, logic v);
        @(negedge clk);
        hash = h; step = s; nonce = n; valid = v;
    endtask

    task automatic idle(int n);
        drive({32'hFFFF_FFFF, 224'h0}, 6'd5, 32'h0, 1'b0);
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc == 100_000) begin
            errors++;
            $display("FAIL watchdog: run did not end, actual=%0d cycles expected<100000", cyc);
            finish_run();
        end
    end

    int unsigned exp_words[$];
    int burst_base;

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(tx_o === 1'b1, "R1", "tx_o in reset", tx_o, 1);
        check(overflow_o === 1'b0, "R1", "overflow_o in reset", overflow_o, 0);
        rst = 1'b0;
        idle(4);

        // R2: near-misses are ignored, lower hash bits do not matter
        tag = "R2";
        drive(256'h0, 6'd1, 32'h5555_0001, 1'b1);                    // step nonzero
        drive(256'h1 << 224, 6'd0, 32'h5555_0002, 1'b1);             // bit 224 set
        drive(256'h1 << 255, 6'd0, 32'h5555_0003, 1'b1);             // bit 255 set
        drive(256'h0, 6'd0, 32'h5555_0004, 1'b0);                    // not valid
        idle(30);
        check(rx_word.size() == 0, "R2", "frames after non-wins", rx_word.size(), 0);
        check(tx_o === 1'b1, "R2", "line after non-wins", tx_o, 1);
        drive({32'h0, {7{32'hCAFE_F00D}}}, 6'd0, 32'h0BAD_C0DE, 1'b1);
        exp_words.push_back(32'h0BAD_C0DE);
        idle(FRAME + 50);

        // R5: start bit one edge after the win is sampled
        tag = "R5";
        drive(256'h0, 6'd0, 32'hA5C3_0F81, 1'b1);
        exp_words.push_back(32'hA5C3_0F81);
        idle(1);
        check(tx_o === 1'b1, "R5", "line at edge of win", tx_o, 1);
        @(negedge clk);
        check(tx_o === 1'b0, "R5", "start bit one edge later", tx_o, 0);
        idle(FRAME + 50);

        // R3: consecutive wins each captured in their own cycle
        tag = "R3";
        drive(256'h0, 6'd0, 32'h1122_3344, 1'b1);
        drive(256'h0, 6'd0, 32'hDEAD_BEEF, 1'b1);
        drive(256'h0, 6'd3, 32'h9999_9999, 1'b1);
        drive(256'h0, 6'd0, 32'h0000_0000, 1'b1);
        exp_words.push_back(32'h1122_3344);
        exp_words.push_back(32'hDEAD_BEEF);
        exp_words.push_back(32'h0000_0000);
        idle(3 * FRAME + 50);

        // R7 / R8: burst overfills the queue
        tag = "R7";
        burst_base = exp_words.size();
        for (int i = 0; i < 20; i++) begin
            drive(256'h0, 6'd0, 32'h1000_0000 + i, 1'b1);
            if (i < DEPTH + 1) exp_words.push_back(32'h1000_0000 + i);
        end
        idle(2);
        check(overflow_o === 1'b1, "R8", "flag after dropped wins", overflow_o, 1);
        idle((DEPTH + 1) * FRAME + 60);
        check(overflow_o === 1'b1, "R8", "flag still set after drain", overflow_o, 1);
        check(tx_o === 1'b1, "R7", "line idle after drain", tx_o, 1);

        // R1 / R8: reset clears the flag
        tag = "R8";
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        check(overflow_o === 1'b0, "R8", "flag cleared by reset", overflow_o, 0);
        check(tx_o === 1'b1, "R1", "line high after reset", tx_o, 1);
        rst = 1'b0;
        tag = "R4";
        drive(256'h0, 6'd0, 32'h7E57_0001, 1'b1);
        exp_words.push_back(32'h7E57_0001);
        idle(FRAME + 50);

        // R4 / R7: decoded words, framing and order
        check(rx_word.size() == exp_words.size(), "R7", "frame count", rx_word.size(), exp_words.size());
        for (int i = 0; i < exp_words.size() && i < rx_word.size(); i++) begin
            check(rx_word[i] == exp_words[i], "R4", "decoded nonce", rx_word[i], exp_words[i]);
            check(rx_ok[i], "R4", "start/stop framing", rx_ok[i], 1);
        end
        // R6: queued frames follow each other with no idle cycle
        for (int i = burst_base + 1; i < burst_base + DEPTH + 1 && i < rx_start.size(); i++)
            check(rx_start[i] - rx_start[i-1] == FRAME, "R6", "frame spacing",
                  rx_start[i] - rx_start[i-1], FRAME);
        finish_run();
    end
endmodule